// File: doc/BRIEF.md
# Flash Block Program, Erase and Lock Engine

This engine keeps the per-block state of a flash array that is split into equal blocks (64 KiB each by default, up to 64 of them). It takes one command at a time from a simple valid/ready command port and drives a synchronous byte-wide memory port toward the array. Programming reads the addressed byte and writes back the AND of the old and new values, so programming can only clear bits. Erasing a block first reports the block as busy, then waits a configurable number of cycles, and then fills every byte of the block with 0xFF. After that it increments the block's erase counter and unlocks the block.

Each block holds a true lock bit and a reported lock bit. The true lock bit starts from a parameter that stands for the state kept in the array. The reported lock bit always comes out of reset as locked and is only brought in line with the true one by an explicit refresh command. A write-protect input governs three cases. A program to a block reported as locked fails with sticky failure flags. An erase of such a block completes silently without touching the array. Every lock request fails while protection is on. Erase requests queue in a small FIFO and run one at a time, in the order they arrived. A status byte and the erase counter of any block can be read through a selector, and a combined compatibility status byte is always visible.

Top module: `flash_blk_engine`

## Requirements
- R1: A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. The operation codes are 0 program, 1 erase, 2 lock and 3 refresh. The target block is `cmd_addr >> BLOCK_AW`. `stat_sel` selects which block's status and erase counter appear on the outputs.
- R2: An accepted program to a block that is not failing issues one memory read of `cmd_addr`, and in the next cycle one write to the same address of `mem_rdata & cmd_data`.
- R3: A program to a block whose reported lock bit is set, accepted while `wp` is high, writes nothing. It sets that block's failed bit (status bit 5) and both failure bits of the compatibility status (bits 5 and 4).
- R4: An accepted erase clears the block's ready bit (status bit 7) and the compatibility ready bit (bit 7) from the next cycle on. After `BUSY_CYCLES` cycles it writes 0xFF to every byte of the block in ascending address order. It then increments the block's erase counter, clears both lock bits (status bit 6 reads 1) and sets ready again.
- R5: An erase of a block whose reported lock bit is set, reaching the end of its busy interval while `wp` is high, writes nothing and leaves the erase counter unchanged. It sets no failure bit and restores ready.
- R6: A lock request accepted while `wp` is high sets the block's failed bit and the compatibility failure bits, even when the block is already locked. With `wp` low it sets both lock bits (status bit 6 reads 0).
- R7: The block status byte is {ready, not-locked, failed, aborted, queue-full, Vpp-low, 0, 0}. The compatibility byte is {ready, erase-suspended, erase-failed, write-failed, Vpp-low, 0, 0, 0}. Aborted, queue-full, Vpp-low and suspended always read 0. After reset every block reads 0x80 and the compatibility byte reads 0x80.
- R8: After reset, a block's reported lock bit is set whatever the value of `LOCK_INIT`. A refresh command copies every block's true lock bit (initially `LOCK_INIT`) into its reported lock bit.
- R9: Erases run one at a time in acceptance order. `cmd_ready` is low while a program is in progress, while a fill is about to start or running, and while the erase queue is full.
- R10: Failure flags stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine can accept a command |
| cmd_op | input | 2 | Operation code (0 program, 1 erase, 2 lock, 3 refresh) |
| cmd_addr | input | BLOCK_AW+log2(NUM_BLOCKS) | Byte address; upper bits select the block |
| cmd_data | input | 8 | Program data |
| wp | input | 1 | Write protection active |
| stat_sel | input | log2(NUM_BLOCKS) | Block whose status and counter are shown |
| blk_status | output | 8 | Status byte of the selected block |
| blk_erase_count | output | CNT_W | Erase counter of the selected block |
| compat_status | output | 8 | Combined compatibility status byte |
| mem_re | output | 1 | Array read strobe |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | BLOCK_AW+log2(NUM_BLOCKS) | Array byte address |
| mem_wdata | output | 8 | Array write data |
| mem_rdata | input | 8 | Array read data, valid the cycle after `mem_re` |

## Verification
The hardest situation to reach is the silent erase skip. It needs a block that is reported as locked and an erase whose busy interval ends while protection is on. An earlier successful erase would have cleared the lock. The bench therefore first locks the block with protection off, then raises `wp` and queues the erase. The bench also enqueues two erases back to back, so that the scoreboard sees their fills in order. It performs refresh on a block map where the true and reported locks differ, so that the copy is visible.

// File: rtl/fbe_pkg.sv
package fbe_pkg;

   typedef enum logic [1:0] {
      OP_PROG    = 2'd0,
      OP_ERASE   = 2'd1,
      OP_LOCK    = 2'd2,
      OP_REFRESH = 2'd3
   } fbe_op_e;

   // Per-block status: ready, unlocked, failed, aborted, qfull, vpp, 2 spare
   function automatic logic [7:0] fbe_blk_byte(input logic rdy, input logic locked,
                                               input logic fail);
      return {rdy, ~locked, fail, 1'b0, 1'b0, 1'b0, 2'b00};
   endfunction

   // Compatibility status: ready, suspended, erase-fail, write-fail, vpp, 3 spare
   function automatic logic [7:0] fbe_compat_byte(input logic rdy, input logic fail);
      return {rdy, 1'b0, fail, fail, 1'b0, 3'b000};
   endfunction

endpackage

// File: rtl/fbe_erase_fifo.sv
module fbe_erase_fifo #(
   parameter int W     = 6,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   generate
      if (DEPTH < 1) begin : g_bad
         $error("fbe_erase_fifo: DEPTH must be at least 1");
      end

      if (DEPTH == 1) begin : g_single
         logic         vld;
         logic [W-1:0] slot;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld  <= 1'b0;
               slot <= '0;
            end else if (push && !vld) begin
               vld  <= 1'b1;
               slot <= din;
            end else if (pop && vld) begin
               vld <= 1'b0;
            end
         end
         assign dout  = slot;
         assign empty = !vld;
         assign full  = vld;
      end else begin : g_ring
         localparam int PW = $clog2(DEPTH);
         localparam int CW = $clog2(DEPTH + 1);
         logic [W-1:0]  store [DEPTH];
         logic [PW-1:0] rd_p, wr_p;
         logic [CW-1:0] fill;
         logic          do_push, do_pop;

         assign do_push = push && (fill != CW'(DEPTH));
         assign do_pop  = pop && (fill != '0);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rd_p <= '0;
               wr_p <= '0;
               fill <= '0;
               for (int k = 0; k < DEPTH; k++) store[k] <= '0;
            end else begin
               if (do_push) begin
                  store[wr_p] <= din;
                  wr_p <= (wr_p == PW'(DEPTH - 1)) ? '0 : wr_p + 1'b1;
               end
               if (do_pop)
                  rd_p <= (rd_p == PW'(DEPTH - 1)) ? '0 : rd_p + 1'b1;
               if (do_push && !do_pop)      fill <= fill + 1'b1;
               else if (do_pop && !do_push) fill <= fill - 1'b1;
            end
         end
         assign dout  = store[rd_p];
         assign empty = (fill == '0);
         assign full  = (fill == CW'(DEPTH));
      end
   endgenerate
endmodule

// File: rtl/fbe_block_state.sv
module fbe_block_state
   import fbe_pkg::*;
#(
   parameter int CNT_W     = 32,
   parameter bit INIT_LOCK = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             erase_req,
   input  logic             erase_done,
   input  logic             erase_skip,
   input  logic             lock_ok,
   input  logic             fail_set,
   input  logic             refresh,
   output logic [7:0]       status,
   output logic [CNT_W-1:0] erase_count,
   output logic             rep_lock
);
   logic true_lock, rdy, failed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         true_lock   <= INIT_LOCK;
         rep_lock    <= 1'b1;
         rdy         <= 1'b1;
         failed      <= 1'b0;
         erase_count <= '0;
      end else begin
         if (erase_req)                    rdy <= 1'b0;
         else if (erase_done || erase_skip) rdy <= 1'b1;

         if (refresh) rep_lock <= true_lock;
         if (erase_done) begin
            true_lock   <= 1'b0;
            rep_lock    <= 1'b0;
            erase_count <= erase_count + 1'b1;
         end
         if (lock_ok) begin
            true_lock <= 1'b1;
            rep_lock  <= 1'b1;
         end
         if (fail_set) failed <= 1'b1;
      end
   end

   assign status = fbe_blk_byte(rdy, rep_lock, failed);
endmodule

// File: rtl/fbe_erase_engine.sv
module fbe_erase_engine #(
   parameter int BLOCK_AW    = 16,
   parameter int BID_W       = 6,
   parameter int BUSY_CYCLES = 1000
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [BID_W-1:0]    start_id,
   input  logic                blocked,
   input  logic                hold,
   output logic                idle,
   output logic [BID_W-1:0]    cur_id,
   output logic                fill_req,
   output logic                fill_we,
   output logic [BLOCK_AW-1:0] fill_off,
   output logic                done,
   output logic                skip
);
   localparam int TW = $clog2(BUSY_CYCLES + 1);

   typedef enum logic [1:0] {E_IDLE, E_WAIT, E_FILL} est_e;
   est_e          st;
   logic [TW-1:0] tmr;
   logic          tmr_end;

   generate
      if (BUSY_CYCLES < 1) begin : g_bad
         $error("fbe_erase_engine: BUSY_CYCLES must be at least 1");
      end
   endgenerate

   assign tmr_end  = (st == E_WAIT) && (tmr == '0);
   assign skip     = tmr_end && blocked;
   assign fill_req = tmr_end && !blocked;
   assign fill_we  = (st == E_FILL);
   assign done     = fill_we && (&fill_off);
   assign idle     = (st == E_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= E_IDLE;
         tmr      <= '0;
         cur_id   <= '0;
         fill_off <= '0;
      end else begin
         case (st)
            E_IDLE: if (start) begin
               cur_id <= start_id;
               tmr    <= TW'(BUSY_CYCLES - 1);
               st     <= E_WAIT;
            end
            E_WAIT: begin
               if (tmr != '0) tmr <= tmr - 1'b1;
               else if (blocked) st <= E_IDLE;
               else if (!hold) begin
                  fill_off <= '0;
                  st       <= E_FILL;
               end
            end
            E_FILL: begin
               fill_off <= fill_off + 1'b1;
               if (&fill_off) st <= E_IDLE;
            end
            default: st <= E_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/flash_blk_engine.sv
module flash_blk_engine
   import fbe_pkg::*;
#(
   parameter int                    NUM_BLOCKS  = 4,
   parameter int                    BLOCK_AW    = 16,
   parameter int                    BUSY_CYCLES = 1000,
   parameter int                    QDEPTH      = 4,
   parameter int                    CNT_W       = 32,
   parameter logic [NUM_BLOCKS-1:0] LOCK_INIT   = '1,
   localparam int                   BID_W       = $clog2(NUM_BLOCKS),
   localparam int                   AW          = BLOCK_AW + BID_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   output logic             cmd_ready,
   input  logic [1:0]       cmd_op,
   input  logic [AW-1:0]    cmd_addr,
   input  logic [7:0]       cmd_data,
   input  logic             wp,
   input  logic [BID_W-1:0] stat_sel,
   output logic [7:0]       blk_status,
   output logic [CNT_W-1:0] blk_erase_count,
   output logic [7:0]       compat_status,
   output logic             mem_re,
   output logic             mem_we,
   output logic [AW-1:0]    mem_addr,
   output logic [7:0]       mem_wdata,
   input  logic [7:0]       mem_rdata
);
   generate
      if (NUM_BLOCKS < 2 || NUM_BLOCKS > 64 || (NUM_BLOCKS & (NUM_BLOCKS - 1)) != 0) begin : g_bad_nb
         $error("flash_blk_engine: NUM_BLOCKS must be a power of two in 2..64");
      end
      if (BLOCK_AW < 1) begin : g_bad_aw
         $error("flash_blk_engine: BLOCK_AW must be at least 1");
      end
   endgenerate

   typedef enum logic [1:0] {P_IDLE, P_RD, P_WR} pst_e;
   pst_e          p_st;
   logic [AW-1:0] p_addr;
   logic [7:0]    p_data;

   logic             accept, prog_fail, prog_go, lock_fail, lock_ok, erase_req, refresh;
   logic [BID_W-1:0] cmd_bid, q_id, eng_id;
   logic             q_empty, q_full, q_pop;
   logic             eng_idle, eng_blocked, fill_req, fill_we, eng_done, eng_skip;
   logic [BLOCK_AW-1:0] fill_off;
   logic [NUM_BLOCKS-1:0] rep_lock;
   logic [7:0]       st_arr  [NUM_BLOCKS];
   logic [CNT_W-1:0] cnt_arr [NUM_BLOCKS];
   logic             g_fail;

   // ---------------- command decode ----------------
   assign cmd_bid   = cmd_addr[AW-1:BLOCK_AW];
   assign cmd_ready = (p_st == P_IDLE) && !fill_we && !fill_req && !q_full;
   assign accept    = cmd_valid && cmd_ready;
   assign prog_fail = accept && (cmd_op == OP_PROG) && wp && rep_lock[cmd_bid];
   assign prog_go   = accept && (cmd_op == OP_PROG) && !prog_fail;
   assign lock_fail = accept && (cmd_op == OP_LOCK) && wp;
   assign lock_ok   = accept && (cmd_op == OP_LOCK) && !wp;
   assign erase_req = accept && (cmd_op == OP_ERASE);
   assign refresh   = accept && (cmd_op == OP_REFRESH);

   // ---------------- program read-modify-write ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_st   <= P_IDLE;
         p_addr <= '0;
         p_data <= '0;
      end else begin
         case (p_st)
            P_IDLE: if (prog_go) begin
               p_addr <= cmd_addr;
               p_data <= cmd_data;
               p_st   <= P_RD;
            end
            P_RD:    p_st <= P_WR;
            P_WR:    p_st <= P_IDLE;
            default: p_st <= P_IDLE;
         endcase
      end
   end

   // ---------------- erase queue and engine ----------------
   assign q_pop       = eng_idle && !q_empty;
   assign eng_blocked = wp && rep_lock[eng_id];

   fbe_erase_fifo #(.W(BID_W), .DEPTH(QDEPTH)) u_queue (
      .clk(clk), .rst_n(rst_n), .push(erase_req), .din(cmd_bid),
      .pop(q_pop), .dout(q_id), .empty(q_empty), .full(q_full)
   );

   fbe_erase_engine #(.BLOCK_AW(BLOCK_AW), .BID_W(BID_W), .BUSY_CYCLES(BUSY_CYCLES)) u_eraser (
      .clk(clk), .rst_n(rst_n), .start(q_pop), .start_id(q_id),
      .blocked(eng_blocked), .hold(p_st != P_IDLE), .idle(eng_idle),
      .cur_id(eng_id), .fill_req(fill_req), .fill_we(fill_we),
      .fill_off(fill_off), .done(eng_done), .skip(eng_skip)
   );

   // ---------------- memory port ----------------
   always_comb begin
      mem_re    = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = p_addr;
      mem_wdata = mem_rdata & p_data;
      if (fill_we) begin
         mem_we    = 1'b1;
         mem_addr  = {eng_id, fill_off};
         mem_wdata = 8'hFF;
      end else if (p_st == P_RD) begin
         mem_re = 1'b1;
      end else if (p_st == P_WR) begin
         mem_we = 1'b1;
      end
   end

   // ---------------- per-block state ----------------
   for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_blk
      logic here, eng_here;
      assign here     = (cmd_bid == BID_W'(i));
      assign eng_here = (eng_id == BID_W'(i));

      fbe_block_state #(.CNT_W(CNT_W), .INIT_LOCK(LOCK_INIT[i])) u_state (
         .clk(clk), .rst_n(rst_n),
         .erase_req(erase_req && here),
         .erase_done(eng_done && eng_here),
         .erase_skip(eng_skip && eng_here),
         .lock_ok(lock_ok && here),
         .fail_set((prog_fail || lock_fail) && here),
         .refresh(refresh),
         .status(st_arr[i]),
         .erase_count(cnt_arr[i]),
         .rep_lock(rep_lock[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     g_fail <= 1'b0;
      else if (prog_fail || lock_fail) g_fail <= 1'b1;
   end

   assign blk_status      = st_arr[stat_sel];
   assign blk_erase_count = cnt_arr[stat_sel];
   assign compat_status   = fbe_compat_byte(q_empty && eng_idle, g_fail);

endmodule

// File: rtl/flash_blk_engine_chk.sv
module flash_blk_engine_chk #(
   parameter int AW = 18
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cmd_valid,
   input logic          cmd_ready,
   input logic [1:0]    cmd_op,
   input logic          wp,
   input logic [7:0]    compat_status,
   input logic          mem_re,
   input logic          mem_we,
   input logic [AW-1:0] mem_addr,
   input logic [7:0]    mem_wdata,
   input logic [7:0]    mem_rdata
);
   // R2: every read is followed by a write to the same byte
   p_rmw_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re |=> (mem_we && mem_addr == $past(mem_addr)));

   // R2: the write after a read never raises a bit
   p_clear_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && $past(mem_re)) |-> ((mem_wdata & ~mem_rdata) == 8'h00));

   // R2: one access per cycle at most
   p_port_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_re && mem_we));

   // R3 / R6: failure flags only appear after a command under write protection
   p_fail_needs_wp_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(compat_status[4]) |-> $past(wp && cmd_valid && cmd_ready));

   // R4: combined ready only drops after an accepted erase
   p_busy_from_erase_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(compat_status[7]) |-> $past(cmd_valid && cmd_ready && cmd_op == 2'd1));

   // R9: no command is taken while a program read is outstanding
   p_no_take_in_rmw_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re |-> !cmd_ready);

   // R10: failure flags are sticky
   p_fail_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      compat_status[4] |=> compat_status[4]);
endmodule

bind flash_blk_engine flash_blk_engine_chk #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
   .cmd_op(cmd_op), .wp(wp), .compat_status(compat_status),
   .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
   .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
);

// File: tb/flash_blk_engine_test.sv
`timescale 1ns/1ps
module flash_blk_engine_test;
   localparam int NB    = 4;
   localparam int BAW   = 3;
   localparam int BUSY  = 20;
   localparam int BW    = 2;
   localparam int AW    = BAW + BW;
   localparam int CW    = 16;
   localparam int MSZ   = 1 << AW;
   localparam int BSZ   = 1 << BAW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic          cmd_ready;
   logic [1:0]    cmd_op = '0;
   logic [AW-1:0] cmd_addr = '0;
   logic [7:0]    cmd_data = '0;
   logic          wp = 1'b0;
   logic [BW-1:0] stat_sel = '0;
   logic [7:0]    blk_status, compat_status, mem_wdata;
   logic [CW-1:0] blk_erase_count;
   logic          mem_re, mem_we;
   logic [AW-1:0] mem_addr;
   logic [7:0]    mem_rdata = '0;

   int checks = 0;
   int errors = 0;
   bit done_flag = 1'b0;

   logic [7:0] mem  [MSZ];
   logic [7:0] shad [MSZ];
   int unsigned exp_q [$];

   always #10 clk = ~clk;

   flash_blk_engine #(.NUM_BLOCKS(NB), .BLOCK_AW(BAW), .BUSY_CYCLES(BUSY),
                      .QDEPTH(2), .CNT_W(CW), .LOCK_INIT(4'b1010)) uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data), .wp(wp),
      .stat_sel(stat_sel), .blk_status(blk_status), .blk_erase_count(blk_erase_count),
      .compat_status(compat_status), .mem_re(mem_re), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   // array model
   initial for (int i = 0; i < MSZ; i++) begin
      mem[i]  = 8'((i * 37 + 11) & 255);
      shad[i] = 8'((i * 37 + 11) & 255);
   end

   always @(posedge clk) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      if (mem_re) mem_rdata <= mem[mem_addr];
   end

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // scoreboard monitor: every array write must match the next expected item
   always @(posedge clk) begin
      if (rst_n && mem_we) begin
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R5/R3 unexpected write: actual addr 0x%0h data 0x%0h expected none",
                     mem_addr, mem_wdata);
         end else begin
            int unsigned e;
            e = exp_q.pop_front();
            check("R2/R4/R9 write stream", {mem_addr, mem_wdata}, int'(e));
         end
      end
   end

   task automatic issue(input logic [1:0] op, input logic [AW-1:0] a, input logic [7:0] d);
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      cmd_op = op; cmd_addr = a; cmd_data = d; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic expect_prog(input int a, input logic [7:0] d);
      shad[a] = shad[a] & d;
      exp_q.push_back({a[AW-1:0], shad[a]});
   endtask

   task automatic expect_erase(input int b);
      for (int k = 0; k < BSZ; k++) begin
         shad[b * BSZ + k] = 8'hFF;
         exp_q.push_back({AW'(b * BSZ + k), 8'hFF});
      end
   endtask

   task automatic wait_idle();
      int n = 0;
      while (!(cmd_ready && compat_status[7]) && n < 1000) begin
         @(negedge clk); n++;
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic peek(input int b);
      stat_sel = BW'(b);
      #1;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done_flag) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R7: reset state; R8 reported locks start set
      peek(0); check("R7 reset block0 status", blk_status, 8'h80);
      check("R7 reset erase count", blk_erase_count, 0);
      check("R7 reset compat", compat_status, 8'h80);
      peek(1); check("R8 reset block1 reported locked", blk_status, 8'h80);

      // R8: refresh copies true locks (blocks 1 and 3 locked)
      issue(2'd3, '0, '0);
      peek(0); check("R8 refresh block0 unlocked", blk_status, 8'hC0);
      peek(1); check("R8 refresh block1 locked", blk_status, 8'h80);
      peek(2); check("R8 refresh block2 unlocked", blk_status, 8'hC0);

      // R2: program unlocked block with protection on, then off
      wp = 1'b1;
      expect_prog(2, 8'h3C);
      issue(2'd0, 5'd2, 8'h3C);
      check("R9 ready low during program", cmd_ready, 0);
      wait_idle();
      check("R2 program AND result", mem[2], shad[2]);
      wp = 1'b0;
      expect_prog(5, 8'h0F);
      issue(2'd0, 5'd5, 8'h0F);
      wait_idle();
      check("R2 second program", mem[5], shad[5]);
      check("R1 no fail on unlocked block", compat_status, 8'h80);

      // R4: erase block1 (locked, no protection)
      expect_erase(1);
      issue(2'd1, 5'd8, 8'h00);
      peek(1); check("R4 block1 busy", blk_status, 8'h00);
      check("R4 compat busy", compat_status, 8'h00);
      wait_idle();
      peek(1); check("R4 block1 ready and unlocked", blk_status, 8'hC0);
      check("R4 block1 erase count", blk_erase_count, 1);
      check("R4 block1 filled", {mem[8], mem[11], mem[15]}, 24'hFFFFFF);

      // R9: two erases in order (block2 then block0)
      expect_erase(2);
      expect_erase(0);
      issue(2'd1, 5'd16, 8'h00);
      issue(2'd1, 5'd1, 8'h00);
      wait_idle();
      peek(2); check("R9 block2 count", blk_erase_count, 1);
      peek(0); check("R9 block0 count", blk_erase_count, 1);
      check("R4 block0 byte", mem[2], 8'hFF);

      // R6: lock without protection
      issue(2'd2, 5'd16, 8'h00);
      peek(2); check("R6 lock block2", blk_status, 8'h80);

      // R5: erase of locked block under protection is skipped silently
      wp = 1'b1;
      mem[17] = 8'h12; shad[17] = 8'h12;
      issue(2'd1, 5'd16, 8'h00);
      check("R4 compat busy on skipped erase", compat_status[7], 0);
      wait_idle();
      peek(2); check("R5 skipped erase status", blk_status, 8'h80);
      check("R5 skipped erase count", blk_erase_count, 1);
      check("R5 no failure flags", compat_status, 8'h80);
      check("R5 array untouched", mem[17], 8'h12);

      // R3: program locked block under protection
      issue(2'd0, 5'd17, 8'h00);
      wait_idle();
      peek(2); check("R3 block2 failed", blk_status, 8'hA0);
      check("R3 compat both fail bits", compat_status, 8'hB0);
      check("R3 array untouched", mem[17], 8'h12);

      // R6: lock under protection fails, locked or not
      issue(2'd2, 5'd0, 8'h00);
      peek(0); check("R6 lock fail unlocked block0", blk_status, 8'hE0);
      peek(3); check("R6 block3 before", blk_status[5], 0);
      issue(2'd2, 5'd24, 8'h00);
      peek(3); check("R6 lock fail already-locked block3", blk_status, 8'hA0);

      // R10: flags persist across a later good program
      wp = 1'b0;
      expect_prog(3, 8'h55);
      issue(2'd0, 5'd3, 8'h55);
      wait_idle();
      check("R10 compat flags sticky", compat_status, 8'hB0);
      check("R2 program after erase", mem[3], 8'h55);
      check("R4/R9 scoreboard drained", exp_q.size(), 0);

      done_flag = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule